// File: doc/BRIEF.md
# Six-Channel Synchronous Programmable-Rate Decimator

This block turns six 1-bit oversampled bitstreams into six 16-bit two's-complement sample words. The six streams come from modulators that all run on one shared modulator clock. The block generates that clock itself as a one-cycle enable, `mod_tick`, by dividing the system clock by a master divider and then by a fixed factor of eight. Each channel runs the same third-order cascaded-integrator-comb filter. One 2-bit rate selector chooses how many modulator samples make up one output word: 32, 64, 128 or 256.

All channels share one timebase, so every channel loads its output word on the same clock edge. A single strobe announces all six words together, so the channels have no skew between them. A flag travels with each strobe and tells whether the filter has settled since the last reset or the last rate change. Changing the rate flushes the whole filter, so no sample ever mixes two ratios.

The block is used between a bank of modulators and a consumer that reads all six words on each strobe. The consumer discards words whose settled flag is low.

Top module: `sync_cic_decimator`

## Requirements
- R1: Reset is synchronous and active-high. While `rst` is high at a clock edge, the block clears all filter state. After that edge, `smp_data`, `smp_stb`, `smp_ok` and `mod_tick` all read zero.
- R2: `mod_tick` is a one-cycle pulse that repeats every `MCLK_DIV*MOD_DIV` clocks (8 clocks at the defaults). Each channel takes its `mod_bits` bit at the edge that ends a cycle in which `mod_tick` is high.
- R3: A modulator bit of 1 counts as +1 and a bit of 0 counts as -1. A settled word equals 32768 times the mean input value. An all-ones input saturates to 32767 (0x7FFF). An all-zeros input gives -32768 (0x8000).
- R4: `rate_sel` values 0, 1, 2 and 3 select 32, 64, 128 and 256 modulator samples per output word. `smp_stb` is high in the cycle after the tick that completes a window, so consecutive strobes are exactly ratio×8×`MCLK_DIV` clocks apart.
- R5: One strobe serves all channels. The word for channel c sits on `smp_data[16c+15:16c]`, and all six words update on the same edge.
- R6: `smp_ok` is low with the first two strobes after a reset or a flush and high from the third strobe onward. `smp_ok` rises only together with a strobe.
- R7: A flush happens whenever `rate_sel` differs from its value in the previous cycle. The flush clears the integrators, the comb delays, the window count and the settle count. In the next cycle `smp_ok` is low and no strobe occurs. The sample words keep their last value. The next window begins at the following tick.
- R8: If a flush and a tick fall on the same edge, the flush wins and that modulator sample is discarded. The first strobe after the flush therefore comes ratio×8+1 clocks after the flush edge.
- R9: `smp_stb` is never high for two cycles in a row, and `smp_data` changes only on an edge that raises `smp_stb`.
- R10: Consider a periodic input whose period divides the ratio, for example 6 ones in every 8 bits. From the third strobe after the input starts, such an input gives exactly 32768 times its mean, so the example gives 16384.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Decimation ratio select (0:32, 1:64, 2:128, 3:256) |
| mod_bits | input | 6 | One modulator bit per channel, sampled on ticks |
| mod_tick | output | 1 | Shared modulator clock enable, one cycle wide |
| smp_data | output | 96 | Six 16-bit signed words, channel 0 in the low bits |
| smp_stb | output | 1 | One-cycle strobe when all six words update |
| smp_ok | output | 1 | Settled flag that accompanies each strobe |

## Verification
A rate change and a modulator tick can land on the same edge. That edge may also be the one that would close a window. The bench provokes this case on purpose: every rate change is applied in the cycle in which `mod_tick` is high, right after a window has completed or partway through one. The bench then checks four things:
- no strobe occurs in the following cycle;
- the settled flag has dropped;
- the first strobe under the new ratio arrives at the exact clock that assumes the coinciding sample was discarded;
- the third output under the new ratio has the exact value expected for the new input pattern.

// File: rtl/scd_pkg.sv
package scd_pkg;

  // Per-cycle control shared by every channel.
  typedef struct packed {
    logic tick;   // modulator sample enable
    logic flush;  // rate change: clear all filter state
    logic dump;   // last sample of a window: run combs, load output
  } scd_ctrl_t;

  // log2 of the decimation ratio for a given selector code.
  function automatic int scd_ratio_log2(input int base_log2, input int sel);
    return base_log2 + sel;
  endfunction

endpackage

// File: rtl/scd_scaler.sv
module scd_scaler #(
  parameter int ACC_W     = 26,
  parameter int OUT_W     = 16,
  parameter int ORDER     = 3,
  parameter int LOG2R_MIN = 5,
  parameter int SEL_W     = 2
) (
  input  logic [SEL_W-1:0]        rate,
  input  logic signed [ACC_W-1:0] acc,
  output logic [OUT_W-1:0]        sample
);
  import scd_pkg::*;

  localparam int SH_W = $clog2(ACC_W + 1);
  localparam logic signed [ACC_W-1:0] POS_LIM = ACC_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] NEG_LIM = ~POS_LIM;

  logic [SH_W-1:0]         shamt;
  logic signed [ACC_W-1:0] shifted;

  // The filter gain is ratio^ORDER, so drop ORDER*log2(ratio) - (OUT_W-1) bits.
  assign shamt   = SH_W'(ORDER * scd_ratio_log2(LOG2R_MIN, int'(rate)) - (OUT_W - 1));
  assign shifted = acc >>> shamt;

  always_comb begin
    if (shifted > POS_LIM)      sample = POS_LIM[OUT_W-1:0];
    else if (shifted < NEG_LIM) sample = NEG_LIM[OUT_W-1:0];
    else                        sample = shifted[OUT_W-1:0];
  end

endmodule

// File: rtl/scd_timebase.sv
module scd_timebase
  import scd_pkg::*;
#(
  parameter int DIV       = 8,
  parameter int SEL_W     = 2,
  parameter int LOG2R_MIN = 5,
  parameter int ORDER     = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] rate_sel,
  output scd_ctrl_t        ctrl,
  output logic [SEL_W-1:0] rate_q,
  output logic             tick_out,
  output logic             stb,
  output logic             ok
);

  localparam int LOG2R_MAX = LOG2R_MIN + (1 << SEL_W) - 1;
  localparam int CNT_W     = LOG2R_MAX;
  localparam int DIV_W     = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int SC_W      = $clog2(ORDER) + 1;

  logic [DIV_W-1:0] dcnt;
  logic             tick_q;
  logic [CNT_W-1:0] wcnt;
  logic [CNT_W-1:0] wlast;
  logic [SC_W-1:0]  settle;
  logic             flush;
  logic             dump;
  logic             dcnt_wrap;

  assign dcnt_wrap = (dcnt == DIV_W'(DIV - 1));
  assign flush     = (rate_sel != rate_q);
  assign wlast     = CNT_W'((1 << scd_ratio_log2(LOG2R_MIN, int'(rate_q))) - 1);
  assign dump      = tick_q && !flush && (wcnt == wlast);

  always_comb begin
    ctrl.tick  = tick_q;
    ctrl.flush = flush;
    ctrl.dump  = dump;
  end

  assign tick_out = tick_q;

  // Shared modulator clock enable; never disturbed by a rate change.
  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt   <= '0;
      tick_q <= 1'b0;
    end else begin
      dcnt   <= dcnt_wrap ? '0 : dcnt + 1'b1;
      tick_q <= dcnt_wrap;
    end
  end

  // Window count, settle count, strobe and settled flag.
  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= rate_sel;
      wcnt   <= '0;
      settle <= '0;
      stb    <= 1'b0;
      ok     <= 1'b0;
    end else begin
      rate_q <= rate_sel;
      stb    <= dump;
      if (flush) begin
        wcnt   <= '0;
        settle <= '0;
        ok     <= 1'b0;
      end else if (tick_q) begin
        wcnt <= dump ? '0 : wcnt + 1'b1;
        if (dump) begin
          ok <= (settle == SC_W'(ORDER - 1));
          if (settle != SC_W'(ORDER - 1)) settle <= settle + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/scd_channel.sv
module scd_channel
  import scd_pkg::*;
#(
  parameter int ACC_W     = 26,
  parameter int OUT_W     = 16,
  parameter int ORDER     = 3,
  parameter int LOG2R_MIN = 5,
  parameter int SEL_W     = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  scd_ctrl_t        ctrl,
  input  logic [SEL_W-1:0] rate_q,
  input  logic             bit_in,
  output logic [OUT_W-1:0] data
);

  logic signed [ACC_W-1:0] integ    [ORDER];
  logic signed [ACC_W-1:0] integ_nx [ORDER+1];
  logic signed [ACC_W-1:0] dly      [ORDER];
  logic signed [ACC_W-1:0] comb     [ORDER+1];
  logic [OUT_W-1:0]        scaled;

  // Map the modulator bit to +1 / -1.
  assign integ_nx[0] = bit_in ? ACC_W'(1) : '1;
  assign comb[0]     = integ_nx[ORDER];

  for (genvar k = 0; k < ORDER; k++) begin : g_stage
    assign integ_nx[k+1] = integ[k] + integ_nx[k];
    assign comb[k+1]     = comb[k] - dly[k];

    always_ff @(posedge clk) begin
      if (rst || ctrl.flush) begin
        integ[k] <= '0;
        dly[k]   <= '0;
      end else begin
        if (ctrl.tick) integ[k] <= integ_nx[k+1];
        if (ctrl.dump) dly[k]   <= comb[k];
      end
    end
  end

  scd_scaler #(
    .ACC_W(ACC_W), .OUT_W(OUT_W), .ORDER(ORDER),
    .LOG2R_MIN(LOG2R_MIN), .SEL_W(SEL_W)
  ) u_scl (
    .rate  (rate_q),
    .acc   (comb[ORDER]),
    .sample(scaled)
  );

  always_ff @(posedge clk) begin
    if (rst)            data <= '0;
    else if (ctrl.dump) data <= scaled;
  end

endmodule

// File: rtl/sync_cic_decimator.sv
module sync_cic_decimator
  import scd_pkg::*;
#(
  parameter int NCH       = 6,
  parameter int OUT_W     = 16,
  parameter int MCLK_DIV  = 1,
  parameter int MOD_DIV   = 8,
  parameter int ORDER     = 3,
  parameter int LOG2R_MIN = 5,
  parameter int SEL_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SEL_W-1:0]     rate_sel,
  input  logic [NCH-1:0]       mod_bits,
  output logic                 mod_tick,
  output logic [NCH*OUT_W-1:0] smp_data,
  output logic                 smp_stb,
  output logic                 smp_ok
);

  localparam int DIV       = MCLK_DIV * MOD_DIV;
  localparam int LOG2R_MAX = LOG2R_MIN + (1 << SEL_W) - 1;
  localparam int ACC_W     = 2 + ORDER * LOG2R_MAX;

  scd_ctrl_t        ctrl;
  logic [SEL_W-1:0] rate_q;

  scd_timebase #(
    .DIV(DIV), .SEL_W(SEL_W), .LOG2R_MIN(LOG2R_MIN), .ORDER(ORDER)
  ) u_tb (
    .clk     (clk),
    .rst     (rst),
    .rate_sel(rate_sel),
    .ctrl    (ctrl),
    .rate_q  (rate_q),
    .tick_out(mod_tick),
    .stb     (smp_stb),
    .ok      (smp_ok)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    scd_channel #(
      .ACC_W(ACC_W), .OUT_W(OUT_W), .ORDER(ORDER),
      .LOG2R_MIN(LOG2R_MIN), .SEL_W(SEL_W)
    ) u_ch (
      .clk   (clk),
      .rst   (rst),
      .ctrl  (ctrl),
      .rate_q(rate_q),
      .bit_in(mod_bits[c]),
      .data  (smp_data[c*OUT_W +: OUT_W])
    );
  end

endmodule

// File: rtl/scd_checker.sv
module scd_checker #(
  parameter int SEL_W  = 2,
  parameter int DATA_W = 96
) (
  input logic              clk,
  input logic              rst,
  input logic [SEL_W-1:0]  rate_sel,
  input logic              mod_tick,
  input logic              smp_stb,
  input logic              smp_ok,
  input logic [DATA_W-1:0] smp_data
);

  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (rst) mod_tick |=> !mod_tick) else $error("tick wider than one cycle"); // R2

  AST_STB_AFTER_TICK: assert property (@(posedge clk) disable iff (rst) smp_stb |-> $past(mod_tick)) else $error("strobe without preceding tick"); // R4

  AST_OK_WITH_STB: assert property (@(posedge clk) disable iff (rst) $rose(smp_ok) |-> smp_stb) else $error("settled flag rose without strobe"); // R6

  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (rst) (rate_sel != $past(rate_sel)) |=> (!smp_stb && !smp_ok)) else $error("activity right after flush"); // R7

  AST_STB_PULSE: assert property (@(posedge clk) disable iff (rst) smp_stb |=> !smp_stb) else $error("strobe wider than one cycle"); // R9

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst) !smp_stb |-> $stable(smp_data)) else $error("data moved without strobe"); // R9

endmodule

bind sync_cic_decimator scd_checker #(
  .SEL_W (SEL_W),
  .DATA_W(NCH*OUT_W)
) u_scd_chk (
  .clk     (clk),
  .rst     (rst),
  .rate_sel(rate_sel),
  .mod_tick(mod_tick),
  .smp_stb (smp_stb),
  .smp_ok  (smp_ok),
  .smp_data(smp_data)
);

// File: tb/test_sync_cic_decimator.sv
module test_sync_cic_decimator;
  localparam int NCH   = 6;
  localparam int OUT_W = 16;
  localparam int DW    = NCH * OUT_W;
  localparam int M_FRESH = 0, M_FLUSH = 1, M_CONT = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    rate_sel = 2'd0;
  logic [NCH-1:0] mod_bits = '0;
  logic          mod_tick, smp_stb, smp_ok;
  logic [DW-1:0] smp_data;

  sync_cic_decimator i_sync_cic_decimator (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .mod_bits(mod_bits),
    .mod_tick(mod_tick), .smp_data(smp_data), .smp_stb(smp_stb), .smp_ok(smp_ok)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;

  typedef struct {
    bit            ok;
    bit            chk;
    logic [DW-1:0] data;
    int            t_at;
  } item_t;
  item_t q[$];

  logic [7:0] cur_pat [NCH];

  task automatic check(input bit cond, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  // Settled value for a period-8 pattern: 32768 * mean, clamped.
  function automatic int expv(input logic [7:0] p);
    int pc;
    pc = $countones(p);
    return (pc == 8) ? 32767 : 4096 * (2 * pc - 8);
  endfunction

  task automatic wait_tick();
    do @(negedge clk); while (mod_tick !== 1'b1);
  endtask

  task automatic drive(input int n);
    for (int c = 0; c < NCH; c++) mod_bits[c] = cur_pat[c][n % 8];
  endtask

  // Scoreboard driver: push expected outputs, then feed the bitstreams.
  task automatic run_seg(input int mode, input logic [1:0] rate, input int nout);
    int r;
    int t0;
    logic [DW-1:0] ed;
    item_t it;
    r = 32 << rate;
    for (int c = 0; c < NCH; c++) ed[c*OUT_W +: OUT_W] = OUT_W'(expv(cur_pat[c]));
    wait_tick();
    t0 = cyc;
    for (int j = 1; j <= nout; j++) begin
      it.ok   = (mode == M_CONT) || (j >= 3);
      it.chk  = (j >= 3);
      it.data = ed;
      it.t_at = (mode == M_FLUSH) ? t0 + 1 + 8 * r * j : t0 + 1 + 8 * (r * j - 1);
      q.push_back(it);
    end
    if (mode == M_FLUSH) begin
      rate_sel = rate;  // coincides with a tick: that sample is dropped
      @(negedge clk);
      check(!smp_stb && !smp_ok, "R7 R8", "stb/ok after flush", {smp_stb, smp_ok}, 0);
    end
    for (int n = 0; n < nout * r; n++) begin
      if (n > 0 || mode == M_FLUSH) wait_tick();
      drive(n);
    end
  endtask

  task automatic partial(input int k);
    for (int n = 0; n < k; n++) begin
      wait_tick();
      drive(n);
    end
  endtask

  // Monitor: pop and compare on every strobe.
  logic [DW-1:0] last_data = '0, prev_data = '0;
  logic          prev_stb = 1'b0;
  always @(negedge clk) begin
    item_t it;
    if (rst) begin
      prev_stb  = 1'b0;
      last_data = '0;
      prev_data = '0;
    end else begin
      if (smp_stb) begin
        check(!prev_stb, "R9", "strobe width", 2, 1);
        check(prev_data == last_data, "R9", "data moved between strobes",
              longint'(prev_data[OUT_W-1:0]), longint'(last_data[OUT_W-1:0]));
        if (q.size() == 0) begin
          check(1'b0, "R4", "unexpected strobe at cycle", cyc, -1);
        end else begin
          it = q.pop_front();
          check(cyc == it.t_at, "R4", "strobe cycle", cyc, it.t_at);
          check(smp_ok == it.ok, "R6", "settled flag", smp_ok, it.ok);
          if (it.chk) begin
            for (int c = 0; c < NCH; c++)
              check(smp_data[c*OUT_W +: OUT_W] == it.data[c*OUT_W +: OUT_W],
                    "R3 R5 R10", $sformatf("channel %0d word", c),
                    $signed(smp_data[c*OUT_W +: OUT_W]), $signed(it.data[c*OUT_W +: OUT_W]));
          end
        end
        last_data = smp_data;
      end
      prev_stb  = smp_stb;
      prev_data = smp_data;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    int t;
    // R1: reset state
    repeat (4) @(negedge clk);
    check(smp_data == '0, "R1", "data in reset", longint'(smp_data[OUT_W-1:0]), 0);
    check(!smp_stb && !smp_ok && !mod_tick, "R1", "stb/ok/tick in reset",
          {smp_stb, smp_ok, mod_tick}, 0);
    rst = 1'b0;

    // Ratio 32, extreme and fractional densities on different channels.
    cur_pat = '{8'hFF, 8'h00, 8'h0F, 8'h3F, 8'h81, 8'h7F};
    run_seg(M_FRESH, 2'd0, 5);
    // New patterns without a flush, aligned to the window boundary.
    cur_pat = '{8'h55, 8'hFF, 8'h01, 8'h00, 8'hEF, 8'h33};
    run_seg(M_CONT, 2'd0, 4);
    // Part of a window, then a rate change that must flush it.
    partial(13);
    cur_pat = '{8'h00, 8'hFF, 8'h3F, 8'h81, 8'h0F, 8'h7F};
    run_seg(M_FLUSH, 2'd3, 3);
    cur_pat = '{8'h7F, 8'h01, 8'hFF, 8'h0F, 8'h00, 8'h3F};
    run_seg(M_FLUSH, 2'd1, 4);
    cur_pat = '{8'h3F, 8'hEF, 8'h00, 8'hFF, 8'h81, 8'h55};
    run_seg(M_FLUSH, 2'd2, 4);

    // Reset in the middle of a run must clear the held words.
    repeat (3) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(smp_data == '0, "R1", "data after second reset", longint'(smp_data[OUT_W-1:0]), 0);
    check(!smp_ok, "R1", "ok after second reset", smp_ok, 0);
    rst = 1'b0;
    cur_pat = '{8'h81, 8'h7F, 8'h55, 8'h01, 8'hFF, 8'h00};
    run_seg(M_FRESH, 2'd2, 3);
    repeat (3) @(negedge clk);

    // R2: tick spacing and width
    wait_tick();
    t = cyc;
    @(negedge clk);
    check(!mod_tick, "R2", "tick width", mod_tick, 0);
    wait_tick();
    check(cyc - t == 8, "R2", "tick period", cyc - t, 8);

    check(q.size() == 0, "R4", "outputs still pending", q.size(), 0);
    finish_run();
  end

endmodule